// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an 8-bit accumulator datapath in the classic 8080 style. Each cycle it takes the accumulator, a second operand, a 16-bit register pair and an operation code, and it returns the new 8-bit value and the new 16-bit pair value as combinational outputs. The five condition flags (sign, zero, auxiliary carry, parity, carry) live in a register inside the block. They feed back into carry-dependent operations and are updated at the clock edge when an operation is strobed.

The flags are always visible as a packed status byte. The same byte can be written back from a bus, for example when a saved status word is restored from the stack. The fixed bits of that byte are forced to their constant values on every write. Several flag rules are reproduced exactly, quirks included: the auxiliary carry after AND and after decrement, and the two-step decimal adjust. Instruction decode, the register file and memory are outside this block.

Top module: `accAlu`

## Requirements
- R1: The status byte `pswOut` is {sign, zero, 0, aux, 0, parity, 1, carry} from bit 7 down to bit 0. After reset it reads 8'h02. When `pswLoad` is high, the flags take the matching bits of `pswIn` at the clock edge, and bits 1, 3 and 5 keep their fixed values whatever `pswIn` holds.
- R2: Every operation that sets zero, sign and parity takes them from its 8-bit computed value: zero when the value is 0, sign equal to bit 7, parity 1 when the count of ones is even. Compare uses the difference.
- R3: Operation codes 0 (add) and 1 (add with carry in) return accIn + operandIn + cin. Carry is bit 8 and aux is bit 4 of (sum XOR accIn XOR operandIn).
- R4: Codes 2 (subtract), 3 (subtract with borrow) and 7 (compare) add the inverted operand with the inverted borrow-in, then invert the carry so that it reads as a borrow. Aux is the raw bit 4 of that addition. Compare returns accIn unchanged.
- R5: Code 4 (AND) clears carry and sets aux to bit 3 of (accIn OR operandIn). Codes 5 (XOR) and 6 (OR) clear both carry and aux.
- R6: Codes 8 (increment) and 9 (decrement) act on operandIn and leave carry unchanged. Increment sets aux when the old low nibble was 4'hF. Decrement sets aux unless the new low nibble is 4'hF.
- R7: Codes 10 and 11 rotate accIn left and right through itself, and the bit shifted out goes to carry. Codes 12 and 13 rotate left and right through carry, with the old carry as the incoming bit. No other flag changes.
- R8: Code 14 (decimal adjust) first adds 8'h06 if the low nibble exceeds 9 or aux is set, with aux becoming (low nibble > 9). It then adds 8'h60 if the new high nibble exceeds 9 or carry is set, with carry becoming (that high nibble > 9). Zero, sign and parity follow from the final value.
- R9: Code 15 returns the complement of accIn and changes no flag. Code 16 sets carry and code 17 inverts carry. Both leave every other flag unchanged and return accIn.
- R10: Code 18 returns hlIn + pairIn on `hlOut` modulo 2^16. Carry is set on unsigned overflow, and no other flag changes. For every other code, `hlOut` equals `hlIn`.
- R11: When `pswLoad` and `opValid` are high in the same cycle, the loaded byte wins and the operation's flag update is dropped.
- R12: With `opValid` low, or with an unassigned code (19 to 31), `resultOut` equals accIn, `hlOut` equals hlIn, and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation strobe; the flags update at the edge |
| opCode | input | 5 | Operation code (see requirements) |
| accIn | input | 8 | Accumulator value |
| operandIn | input | 8 | Second operand; source for increment and decrement |
| hlIn | input | 16 | 16-bit destination pair |
| pairIn | input | 16 | 16-bit pair added by code 18 |
| pswLoad | input | 1 | Load the flags from pswIn |
| pswIn | input | 8 | Status byte to load |
| resultOut | output | 8 | Combinational 8-bit result |
| hlOut | output | 16 | Combinational 16-bit result |
| pswOut | output | 8 | Packed status byte from the flag register |

## Verification
The two functions that can collide are a status-byte restore and a flag-updating operation, since both write the flag register at the same edge. The bench drives `pswLoad` together with a set-carry operation, and separately together with an add that would set carry and zero. It then checks that `pswOut` holds exactly the loaded byte, with its fixed bits forced, while `resultOut` still shows the operation's combinational value in the cycle before the edge. Single-source loads with all-ones and all-zeros bytes serve as the reference for the forced bits.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBB = 5'd3,
    OP_AND = 5'd4, OP_XOR = 5'd5, OP_OR  = 5'd6, OP_CMP = 5'd7,
    OP_INC = 5'd8, OP_DEC = 5'd9, OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_DAA = 5'd14, OP_CMA = 5'd15,
    OP_STC = 5'd16, OP_CMC = 5'd17, OP_DAD = 5'd18
  } aluOpE;

  typedef enum logic [3:0] {
    RS_PASS, RS_ARITH, RS_LOGIC, RS_STEP, RS_ROT,
    RS_DECADJ, RS_NOT, RS_SETC, RS_CMC, RS_DAD
  } resSelE;

  typedef enum logic [1:0] { LG_AND, LG_XOR, LG_OR } logicSelE;
  typedef enum logic [1:0] { RT_LEFT, RT_RIGHT, RT_LEFT_C, RT_RIGHT_C } rotSelE;
  typedef enum logic [1:0] { CI_ZERO, CI_CARRY, CI_ONE, CI_NOTCARRY } cinSelE;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flagsT;

  typedef struct packed {
    resSelE   resSel;
    logicSelE logicSel;
    rotSelE   rotSel;
    cinSelE   cinSel;
    logic     invOperand;
    logic     keepAcc;
    logic     stepDown;
    logic     updZsp;
    logic     updCy;
    logic     updAc;
    logic     flagWe;
    logic     pswWe;
  } strobesT;
endpackage

// File: rtl/accAluCtl.sv
module accAluCtl
  import accAluPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  input  logic            pswLoad,
  output strobesT         st
);
  logic known;

  always_comb begin
    st          = '0;
    st.resSel   = RS_PASS;
    st.logicSel = LG_AND;
    st.rotSel   = RT_LEFT;
    st.cinSel   = CI_ZERO;
    known       = 1'b1;
    unique case (opCode)
      OP_ADD: begin st.resSel = RS_ARITH; st.cinSel = CI_ZERO; end
      OP_ADC: begin st.resSel = RS_ARITH; st.cinSel = CI_CARRY; end
      OP_SUB: begin st.resSel = RS_ARITH; st.cinSel = CI_ONE; st.invOperand = 1'b1; end
      OP_SBB: begin st.resSel = RS_ARITH; st.cinSel = CI_NOTCARRY; st.invOperand = 1'b1; end
      OP_CMP: begin
        st.resSel = RS_ARITH; st.cinSel = CI_ONE; st.invOperand = 1'b1; st.keepAcc = 1'b1;
      end
      OP_AND: begin st.resSel = RS_LOGIC; st.logicSel = LG_AND; end
      OP_XOR: begin st.resSel = RS_LOGIC; st.logicSel = LG_XOR; end
      OP_OR:  begin st.resSel = RS_LOGIC; st.logicSel = LG_OR; end
      OP_INC: begin st.resSel = RS_STEP; end
      OP_DEC: begin st.resSel = RS_STEP; st.stepDown = 1'b1; end
      OP_RLC: begin st.resSel = RS_ROT; st.rotSel = RT_LEFT; end
      OP_RRC: begin st.resSel = RS_ROT; st.rotSel = RT_RIGHT; end
      OP_RAL: begin st.resSel = RS_ROT; st.rotSel = RT_LEFT_C; end
      OP_RAR: begin st.resSel = RS_ROT; st.rotSel = RT_RIGHT_C; end
      OP_DAA: st.resSel = RS_DECADJ;
      OP_CMA: st.resSel = RS_NOT;
      OP_STC: st.resSel = RS_SETC;
      OP_CMC: st.resSel = RS_CMC;
      OP_DAD: st.resSel = RS_DAD;
      default: known = 1'b0;
    endcase

    case (st.resSel)
      RS_ARITH, RS_LOGIC, RS_DECADJ: begin
        st.updZsp = 1'b1; st.updCy = 1'b1; st.updAc = 1'b1;
      end
      RS_STEP: begin st.updZsp = 1'b1; st.updAc = 1'b1; end
      RS_ROT, RS_SETC, RS_CMC, RS_DAD: st.updCy = 1'b1;
      default: ;
    endcase

    if (!opValid) begin
      st.resSel   = RS_PASS;
      st.keepAcc  = 1'b0;
    end
    st.flagWe = opValid & known & ~pswLoad;
    st.pswWe  = pswLoad;
  end

  // R11: a status-byte load always suppresses the operation's flag write
  p_psw_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    pswLoad |-> !st.flagWe);

  // R12: without a strobe nothing reaches the flags through the op path
  p_idle_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!st.flagWe && st.resSel == RS_PASS));
endmodule

// File: rtl/accAluDp.sv
module accAluDp
  import accAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           st,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [PAIR_W-1:0] hlIn,
  input  logic [PAIR_W-1:0] pairIn,
  input  logic [DATA_W-1:0] pswIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [PAIR_W-1:0] hlOut,
  output logic [DATA_W-1:0] pswOut
);
  localparam logic [NIB_W-1:0]  NIB_MAX   = '1;
  localparam logic [NIB_W-1:0]  NIB_DEC   = NIB_W'(9);
  localparam logic [DATA_W-1:0] LOW_FIX   = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] HIGH_FIX  = DATA_W'(8'h60);

  flagsT flagQ;

  // adder shared by add, subtract and compare
  logic [DATA_W-1:0] bOp;
  logic              cinBit;
  logic [DATA_W:0]   sumW;
  logic [DATA_W:0]   carryVec;
  always_comb begin
    bOp = st.invOperand ? ~operandIn : operandIn;
    case (st.cinSel)
      CI_ZERO:     cinBit = 1'b0;
      CI_CARRY:    cinBit = flagQ.carry;
      CI_ONE:      cinBit = 1'b1;
      default:     cinBit = ~flagQ.carry;
    endcase
    sumW     = {1'b0, accIn} + {1'b0, bOp} + {{DATA_W{1'b0}}, cinBit};
    carryVec = sumW ^ {1'b0, accIn} ^ {1'b0, bOp};
  end

  // increment and decrement on the operand
  logic [DATA_W-1:0] stepVal;
  logic              stepAc;
  always_comb begin
    stepVal = st.stepDown ? operandIn - 1'b1 : operandIn + 1'b1;
    stepAc  = st.stepDown ? (stepVal[NIB_W-1:0] != NIB_MAX)
                          : (operandIn[NIB_W-1:0] == NIB_MAX);
  end

  // decimal adjust in two steps
  logic              lowBig, highBig;
  logic [DATA_W-1:0] daaStep1, daaVal;
  always_comb begin
    lowBig   = accIn[NIB_W-1:0] > NIB_DEC;
    daaStep1 = (lowBig || flagQ.aux) ? accIn + LOW_FIX : accIn;
    highBig  = daaStep1[DATA_W-1:NIB_W] > NIB_DEC;
    daaVal   = (highBig || flagQ.carry) ? daaStep1 + HIGH_FIX : daaStep1;
  end

  // 16-bit pair add
  logic [PAIR_W:0] dadSum;
  assign dadSum = {1'b0, hlIn} + {1'b0, pairIn};

  // value select and flag candidates
  logic [DATA_W-1:0] val;
  logic              cyNew, acNew;
  always_comb begin
    val   = accIn;
    cyNew = flagQ.carry;
    acNew = flagQ.aux;
    case (st.resSel)
      RS_ARITH: begin
        val   = sumW[DATA_W-1:0];
        cyNew = carryVec[DATA_W] ^ st.invOperand;
        acNew = carryVec[NIB_W];
      end
      RS_LOGIC: begin
        cyNew = 1'b0;
        case (st.logicSel)
          LG_AND:  begin val = accIn & operandIn; acNew = accIn[NIB_W-1] | operandIn[NIB_W-1]; end
          LG_XOR:  begin val = accIn ^ operandIn; acNew = 1'b0; end
          default: begin val = accIn | operandIn; acNew = 1'b0; end
        endcase
      end
      RS_STEP: begin val = stepVal; acNew = stepAc; end
      RS_ROT: begin
        case (st.rotSel)
          RT_LEFT:    begin val = {accIn[DATA_W-2:0], accIn[DATA_W-1]}; cyNew = accIn[DATA_W-1]; end
          RT_RIGHT:   begin val = {accIn[0], accIn[DATA_W-1:1]};        cyNew = accIn[0]; end
          RT_LEFT_C:  begin val = {accIn[DATA_W-2:0], flagQ.carry};     cyNew = accIn[DATA_W-1]; end
          default:    begin val = {flagQ.carry, accIn[DATA_W-1:1]};     cyNew = accIn[0]; end
        endcase
      end
      RS_DECADJ: begin val = daaVal; cyNew = highBig; acNew = lowBig; end
      RS_NOT:    val = ~accIn;
      RS_SETC:   cyNew = 1'b1;
      RS_CMC:    cyNew = ~flagQ.carry;
      RS_DAD:    cyNew = dadSum[PAIR_W];
      default:   ;
    endcase
  end

  assign resultOut = st.keepAcc ? accIn : val;
  assign hlOut     = (st.resSel == RS_DAD) ? dadSum[PAIR_W-1:0] : hlIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (st.pswWe) begin
      flagQ.sign   <= pswIn[7];
      flagQ.zero   <= pswIn[6];
      flagQ.aux    <= pswIn[4];
      flagQ.parity <= pswIn[2];
      flagQ.carry  <= pswIn[0];
    end else if (st.flagWe) begin
      if (st.updZsp) begin
        flagQ.sign   <= val[DATA_W-1];
        flagQ.zero   <= (val == '0);
        flagQ.parity <= ~^val;
      end
      if (st.updCy) flagQ.carry <= cyNew;
      if (st.updAc) flagQ.aux   <= acNew;
    end
  end

  assign pswOut = {flagQ.sign, flagQ.zero, 1'b0, flagQ.aux, 1'b0,
                   flagQ.parity, 1'b1, flagQ.carry};

  // R1: a loaded byte appears with its fixed bits forced
  p_psw_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    st.pswWe |=> pswOut == (($past(pswIn) & 8'hD5) | 8'h02));

  // R12: no write strobe, no flag change
  p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!st.flagWe && !st.pswWe) |=> $stable(pswOut));

  // R6: increment and decrement never touch carry
  p_step_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagWe && st.resSel == RS_STEP) |=> pswOut[0] == $past(pswOut[0]));

  // R9 and R10: carry-only operations leave the other flags alone
  p_carry_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagWe && st.resSel inside {RS_SETC, RS_CMC, RS_DAD, RS_ROT})
      |=> pswOut[7:1] == $past(pswOut[7:1]));

  // R9: complement of the accumulator leaves every flag alone
  p_not_no_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagWe && st.resSel == RS_NOT) |=> $stable(pswOut));
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [PAIR_W-1:0] hlIn,
  input  logic [PAIR_W-1:0] pairIn,
  input  logic              pswLoad,
  input  logic [DATA_W-1:0] pswIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [PAIR_W-1:0] hlOut,
  output logic [DATA_W-1:0] pswOut
);
  strobesT st;

  accAluCtl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .pswLoad (pswLoad),
    .st      (st)
  );

  accAluDp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .accIn     (accIn),
    .operandIn (operandIn),
    .hlIn      (hlIn),
    .pairIn    (pairIn),
    .pswIn     (pswIn),
    .resultOut (resultOut),
    .hlOut     (hlOut),
    .pswOut    (pswOut)
  );
endmodule

// File: tb/tb_accAlu.sv
module tb_accAlu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [7:0]  accIn = '0, operandIn = '0, pswIn = '0;
  logic [15:0] hlIn = '0, pairIn = '0;
  logic        pswLoad = 1'b0;
  logic [7:0]  resultOut, pswOut;
  logic [15:0] hlOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expPsw = 8'h02;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  accAlu dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operandIn(operandIn), .hlIn(hlIn), .pairIn(pairIn),
    .pswLoad(pswLoad), .pswIn(pswIn),
    .resultOut(resultOut), .hlOut(hlOut), .pswOut(pswOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic void model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] psw, input logic [15:0] hl, input logic [15:0] pr,
                                output logic [7:0] res, output logic [7:0] npsw,
                                output logic [15:0] nhl);
    int ai, bi, t, x;
    logic s, z, p, ac, cy, zsp;
    logic [7:0] v;
    ai = int'(a); bi = int'(b);
    s = psw[7]; z = psw[6]; ac = psw[4]; p = psw[2]; cy = psw[0];
    res = a; nhl = hl; zsp = 1'b0; v = a;
    case (op)
      5'd0, 5'd1: begin
        t = (op == 5'd1) ? int'(psw[0]) : 0;
        x = ai + bi + t;
        v = x[7:0]; cy = (x > 255); ac = ((ai % 16) + (bi % 16) + t) > 15;
        res = v; zsp = 1'b1;
      end
      5'd2, 5'd3, 5'd7: begin
        t = (op == 5'd3) ? int'(psw[0]) : 0;
        x = ai - bi - t;
        v = x[7:0]; cy = (x < 0); ac = ((ai % 16) + (15 - (bi % 16)) + (1 - t)) > 15;
        res = (op == 5'd7) ? a : v; zsp = 1'b1;
      end
      5'd4: begin v = a & b; cy = 0; ac = a[3] | b[3]; res = v; zsp = 1'b1; end
      5'd5: begin v = a ^ b; cy = 0; ac = 0; res = v; zsp = 1'b1; end
      5'd6: begin v = a | b; cy = 0; ac = 0; res = v; zsp = 1'b1; end
      5'd8: begin x = (bi + 1) % 256; v = x[7:0]; ac = (bi % 16) == 15; res = v; zsp = 1'b1; end
      5'd9: begin x = (bi + 255) % 256; v = x[7:0]; ac = (x % 16) != 15; res = v; zsp = 1'b1; end
      5'd10: begin cy = a[7]; res = {a[6:0], a[7]}; end
      5'd11: begin cy = a[0]; res = {a[0], a[7:1]}; end
      5'd12: begin cy = a[7]; res = {a[6:0], psw[0]}; end
      5'd13: begin cy = a[0]; res = {psw[0], a[7:1]}; end
      5'd14: begin
        x = ai;
        if ((x % 16) > 9 || psw[4]) begin ac = (x % 16) > 9; x = (x + 6) % 256; end
        else ac = 0;
        if ((x / 16) > 9 || psw[0]) begin cy = (x / 16) > 9; x = (x + 96) % 256; end
        else cy = 0;
        v = x[7:0]; res = v; zsp = 1'b1;
      end
      5'd15: res = ~a;
      5'd16: cy = 1'b1;
      5'd17: cy = ~psw[0];
      5'd18: begin
        x = int'(hl) + int'(pr);
        nhl = x[15:0]; cy = (x > 65535);
      end
      default: ;
    endcase
    if (zsp) begin
      z = (v == 8'h00); s = v[7]; p = ($countones(v) % 2) == 0;
    end
    npsw = {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  // one strobed operation, checked against the model
  task automatic runOp(input string req, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [15:0] hl, input logic [15:0] pr);
    logic [7:0] eRes, eP;
    logic [15:0] eHl;
    @(negedge clk);
    opValid = 1'b1; opCode = op; accIn = a; operandIn = b; hlIn = hl; pairIn = pr;
    model(op, a, b, expPsw, hl, pr, eRes, eP, eHl);
    #1;
    check({req, " result"}, 32'(resultOut), 32'(eRes));
    check({req, " pair"}, 32'(hlOut), 32'(eHl));
    @(negedge clk);
    opValid = 1'b0;
    check({req, " flags"}, 32'(pswOut), 32'(eP));
    expPsw = eP;
  endtask

  task automatic loadPsw(input logic [7:0] v);
    @(negedge clk);
    pswLoad = 1'b1; pswIn = v;
    @(negedge clk);
    pswLoad = 1'b0;
    expPsw = (v & 8'hD5) | 8'h02;
  endtask

  task automatic testReset();
    #1;
    check("R1 reset psw", 32'(pswOut), 32'h02);
  endtask

  task automatic testPswFixed();
    loadPsw(8'hFF);
    check("R1 load all ones", 32'(pswOut), 32'hD7);
    loadPsw(8'h00);
    check("R1 load all zeros", 32'(pswOut), 32'h02);
  endtask

  task automatic testAdd();
    runOp("R3 add wrap", 5'd0, 8'h3A, 8'hC6, '0, '0);
    check("R2 add zero flags", 32'(pswOut), 32'h57);
    runOp("R3 adc", 5'd1, 8'h0F, 8'h01, '0, '0);
    runOp("R3 add sign", 5'd0, 8'h70, 8'h10, '0, '0);
  endtask

  task automatic testSub();
    runOp("R4 sub borrow", 5'd2, 8'h10, 8'h20, '0, '0);
    check("R4 sub borrow carry", 32'(pswOut[0]), 32'h1);
    runOp("R4 sbb", 5'd3, 8'h10, 8'h0F, '0, '0);
    runOp("R4 cmp equal", 5'd7, 8'h42, 8'h42, '0, '0);
    check("R4 cmp zero", 32'(pswOut[6]), 32'h1);
  endtask

  task automatic testLogic();
    runOp("R5 and aux", 5'd4, 8'h08, 8'h01, '0, '0);
    check("R5 and aux bit", 32'(pswOut[4]), 32'h1);
    loadPsw(8'h11);
    runOp("R5 xor", 5'd5, 8'hA5, 8'h0F, '0, '0);
    loadPsw(8'h11);
    runOp("R5 or", 5'd6, 8'h80, 8'h01, '0, '0);
  endtask

  task automatic testStep();
    loadPsw(8'h01);
    runOp("R6 inc nibble", 5'd8, 8'h00, 8'h0F, '0, '0);
    check("R6 inc keeps carry", 32'(pswOut[0]), 32'h1);
    runOp("R6 inc wrap", 5'd8, 8'h00, 8'hFF, '0, '0);
    runOp("R6 dec to nibble F", 5'd9, 8'h00, 8'h10, '0, '0);
    check("R6 dec aux clear", 32'(pswOut[4]), 32'h0);
    runOp("R6 dec plain", 5'd9, 8'h00, 8'h05, '0, '0);
  endtask

  task automatic testRotate();
    loadPsw(8'h00);
    runOp("R7 rlc", 5'd10, 8'h81, 8'h00, '0, '0);
    runOp("R7 rrc", 5'd11, 8'h01, 8'h00, '0, '0);
    runOp("R7 ral", 5'd12, 8'h40, 8'h00, '0, '0);
    runOp("R7 rar", 5'd13, 8'h02, 8'h00, '0, '0);
  endtask

  task automatic testDaa();
    loadPsw(8'h00);
    runOp("R8 daa both", 5'd14, 8'h9A, 8'h00, '0, '0);
    check("R8 daa flags", 32'(pswOut), 32'h57);
    loadPsw(8'h01);
    runOp("R8 daa carry in", 5'd14, 8'h15, 8'h00, '0, '0);
    loadPsw(8'h10);
    runOp("R8 daa aux in", 5'd14, 8'h23, 8'h00, '0, '0);
  endtask

  task automatic testCarryOps();
    loadPsw(8'hD4);
    runOp("R9 cma", 5'd15, 8'h5A, 8'h00, '0, '0);
    check("R9 cma flags", 32'(pswOut), 32'hD6);
    runOp("R9 stc", 5'd16, 8'h5A, 8'h00, '0, '0);
    runOp("R9 cmc", 5'd17, 8'h5A, 8'h00, '0, '0);
    check("R9 cmc flags", 32'(pswOut), 32'hD6);
  endtask

  task automatic testDad();
    loadPsw(8'hC4);
    runOp("R10 dad overflow", 5'd18, 8'h00, 8'h00, 16'hFFFF, 16'h0001);
    check("R10 dad carry", 32'(pswOut), 32'hC7);
    runOp("R10 dad plain", 5'd18, 8'h00, 8'h00, 16'h1234, 16'h1111);
  endtask

  task automatic testCollision();
    loadPsw(8'h00);
    @(negedge clk);
    pswLoad = 1'b1; pswIn = 8'h80; opValid = 1'b1; opCode = 5'd16; accIn = 8'h33;
    #1;
    check("R11 result during load", 32'(resultOut), 32'h33);
    @(negedge clk);
    check("R11 load beats stc", 32'(pswOut), 32'h82);
    pswIn = 8'h00; opCode = 5'd0; accIn = 8'hFF; operandIn = 8'h01;
    #1;
    check("R11 add value during load", 32'(resultOut), 32'h00);
    @(negedge clk);
    pswLoad = 1'b0; opValid = 1'b0;
    check("R11 load beats add", 32'(pswOut), 32'h02);
    expPsw = 8'h02;
  endtask

  task automatic testIdle();
    loadPsw(8'h45);
    @(negedge clk);
    opValid = 1'b0; opCode = 5'd16; accIn = 8'h9C; hlIn = 16'hABCD; pairIn = 16'h1111;
    #1;
    check("R12 idle result", 32'(resultOut), 32'h9C);
    check("R12 idle pair", 32'(hlOut), 32'hABCD);
    @(negedge clk);
    check("R12 idle flags", 32'(pswOut), 32'h47);
    runOp("R12 unassigned code", 5'd25, 8'h77, 8'h01, 16'h2222, 16'h3333);
    check("R12 unassigned flags", 32'(pswOut), 32'h47);
  endtask

  task automatic testSweep();
    logic [7:0] a, b, f;
    logic [4:0] op;
    for (int i = 0; i < 80; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345; a = seed[23:16];
      seed = seed * 32'd1103515245 + 32'd12345; b = seed[23:16];
      seed = seed * 32'd1103515245 + 32'd12345; f = seed[23:16];
      op = 5'(seed[31:24] % 19);
      loadPsw(f);
      runOp("R2 R3 R4 R8 sweep", op, a, b, {a, b}, {b, a});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPswFixed();
    testAdd();
    testSub();
    testLogic();
    testStep();
    testRotate();
    testDaa();
    testCarryOps();
    testDad();
    testCollision();
    testIdle();
    testSweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule